// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog with a prescaled down-counter. Software keeps it alive with a two-step refresh: first 00h is written to the refresh register, then FFh. It can also require that each refresh lands inside a configurable window of the count. A refresh that arrives too early or too late is flagged as an error. When the counter runs out, the block records an underflow. Both events lead to one action: a reset request or an interrupt, picked by a single bit in the action register.

The counter is idle after reset until the first refresh sequence completes. One control register holds the timeout length, the prescaler ratio and the two window edges. This register, and the action register, each take exactly one write between reset and the first refresh; after that they are locked. A count-enable input qualifies every count step, and a debug-stop input freezes counting. The host reads the live count and the two sticky flags through the status register. Writing zero to a flag clears it.

Top module: `win_wdog`

## Requirements
- R1: After reset, the status register (offset 4) reads 0000h, the control register (offset 2) reads 33F3h, the action register (offset 6) reads 0080h, the refresh register (offset 0) reads 00FFh, and neither rst_req nor irq is asserted.
- R2: A write of FFh to the refresh register reloads the counter only when the previous refresh write was 00h. A lone FFh, or 00h followed by any other value and then FFh, is ignored. The counter stays at 0 and does not count until the first valid sequence.
- R3: A valid refresh loads the counter with the reload value chosen by control bits [1:0]: 00 gives 03FFh, 01 gives 0FFFh, 10 gives 1FFFh and 11 gives 3FFFh. Status bits [13:0] show the live count.
- R4: Control bits [7:4] set the prescaler. 0000 gives one count step per enabled cycle, 0001 one per 4, 0101 one per 256 and 1000 one per 8192; every other code gives one per enabled cycle. Cycles with cnt_en low do not advance it.
- R5: A refresh while the counter is running checks the remaining count rem = count+1 against the period P = reload+1. The window is open when rem <= start and rem > end. Start (bits [13:12]) is 00: P/4, 01: 3P/4, 10: P/2, 11: P. End (bits [9:8]) is 00: 3P/4, 01: P/2, 10: P/4, 11: 0. A refresh outside the window sets the refresh-error flag (status bit 15) and triggers the action. The counter is still reloaded.
- R6: A count step taken at count 0 sets the underflow flag (status bit 14), reloads the counter and triggers the action. A flag stays set until a write to the status register with byte lane 1 enabled carries 0 in that flag's bit. Writing 1 leaves the flag unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R7: The control register and the action register each accept only their first write, and only before the first valid refresh. All later writes to them are ignored.
- R8: The action is a one-cycle pulse on rst_req when action bit 7 is 1, and on irq when it is 0. The pulse appears the cycle after the event. The two outputs are never high together.
- R9: While dbg_stop is high, the counter and the prescaler hold their values.
- R10: Writes use byte lanes. bus_be[0] carries wdata[7:0] and bus_be[1] carries wdata[15:8]. For the control register, only the enabled bytes change. Accesses are halfword aligned: a write with bus_addr[0] set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte offset of the register |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cnt_en | input | 1 | Count-clock enable |
| dbg_stop | input | 1 | Freezes counting while high |
| rst_req | output | 1 | Reset-request pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench checks rst_req and irq against its reference model on every cycle. As a result, a wrong count, a wrong prescaler phase or a wrong window edge shows up as a missing, early or extra pulse. The count can be off by a single step, and that shows up on the status register on the next read. A wrong lock or arming state stays hidden until the next refresh or control write, so the bench reads the registers back right after each such write.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
    localparam int MIN_LOG2 = 10;
    localparam int CNT_W    = MIN_LOG2 + 4;
    localparam int PRE_W    = 13;

    localparam logic [2:0] OFS_KICK = 3'h0;
    localparam logic [2:0] OFS_CTRL = 3'h2;
    localparam logic [2:0] OFS_STAT = 3'h4;
    localparam logic [2:0] OFS_ACT  = 3'h6;

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic cnt_t reload_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return cnt_t'((1 << MIN_LOG2) - 1);
            2'b01:   return cnt_t'((1 << (MIN_LOG2 + 2)) - 1);
            2'b10:   return cnt_t'((1 << (MIN_LOG2 + 3)) - 1);
            default: return cnt_t'((1 << (MIN_LOG2 + 4)) - 1);
        endcase
    endfunction

    typedef struct packed {
        cnt_t        cnt;
        logic        armed;
        logic        run;
        logic [15:0] ctrl;
        logic        ctrl_used;
        logic        act_rst;
        logic        act_used;
        logic        uf;
        logic        re;
        logic        rst_req;
        logic        irq;
    } core_t;
endpackage

// File: rtl/win_wdog_presc.sv
module win_wdog_presc #(
    parameter int PRE_W = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       advance,
    input  logic [3:0] div_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q, pre_d;
    logic [PRE_W-1:0] limit;

    always_comb begin
        case (div_sel)
            4'h1:    limit = PRE_W'(3);
            4'h5:    limit = PRE_W'(255);
            4'h8:    limit = PRE_W'(8191);
            default: limit = '0;
        endcase
    end

    always_comb begin
        tick  = advance && (pre_q == limit);
        pre_d = pre_q;
        if (clear)        pre_d = '0;
        else if (tick)    pre_d = '0;
        else if (advance) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/win_wdog_window.sv
module win_wdog_window #(
    parameter int CNT_W = 14
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] reload,
    input  logic [1:0]       start_sel,
    input  logic [1:0]       end_sel,
    output logic             in_win
);
    logic [CNT_W:0] period, rem, quarter, half, three_q, start_thr, end_thr;

    always_comb begin
        period  = {1'b0, reload} + 1'b1;
        rem     = {1'b0, cnt} + 1'b1;
        quarter = period >> 2;
        half    = period >> 1;
        three_q = half + quarter;
        case (start_sel)
            2'b00:   start_thr = quarter;
            2'b01:   start_thr = three_q;
            2'b10:   start_thr = half;
            default: start_thr = period;
        endcase
        case (end_sel)
            2'b00:   end_thr = three_q;
            2'b01:   end_thr = half;
            2'b10:   end_thr = quarter;
            default: end_thr = '0;
        endcase
        in_win = (rem <= start_thr) && (rem > end_thr);
    end
endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
    parameter logic [15:0] CTRL_RST = 16'h33F3,
    parameter logic        ACT_RST  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        cnt_en,
    input  logic        dbg_stop,
    output logic        rst_req,
    output logic        irq
);
    import win_wdog_pkg::*;

    core_t s_q, s_d;
    logic  wr_hit, kick_wr, ctrl_wr, act_wr, stat_wr;
    logic  refresh, err, uflow, tick, in_win, advance, pre_clr;
    cnt_t  reload;
    logic  run_w, uf_w;
    cnt_t  cnt_w;
    logic [15:0] ctrl_w;

    assign reload  = reload_of(s_q.ctrl[1:0]);
    assign advance = s_q.run && cnt_en && !dbg_stop;

    win_wdog_presc #(.PRE_W(PRE_W)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pre_clr),
        .advance (advance),
        .div_sel (s_q.ctrl[7:4]),
        .tick    (tick)
    );

    win_wdog_window #(.CNT_W(CNT_W)) i_window (
        .cnt       (s_q.cnt),
        .reload    (reload),
        .start_sel (s_q.ctrl[13:12]),
        .end_sel   (s_q.ctrl[9:8]),
        .in_win    (in_win)
    );

    always_comb begin
        s_d     = s_q;
        wr_hit  = bus_wr && !bus_addr[0];
        kick_wr = wr_hit && (bus_addr == OFS_KICK) && bus_be[0];
        ctrl_wr = wr_hit && (bus_addr == OFS_CTRL) && (bus_be != 2'b00);
        act_wr  = wr_hit && (bus_addr == OFS_ACT) && bus_be[0];
        stat_wr = wr_hit && (bus_addr == OFS_STAT) && bus_be[1];
        refresh = kick_wr && (bus_wdata[7:0] == 8'hFF) && s_q.armed;
        pre_clr = refresh || !s_q.run;

        if (kick_wr) s_d.armed = (bus_wdata[7:0] == 8'h00);

        if (ctrl_wr && !s_q.run && !s_q.ctrl_used) begin
            s_d.ctrl_used = 1'b1;
            if (bus_be[0]) s_d.ctrl[7:0]  = bus_wdata[7:0];
            if (bus_be[1]) s_d.ctrl[15:8] = bus_wdata[15:8];
        end

        if (act_wr && !s_q.run && !s_q.act_used) begin
            s_d.act_used = 1'b1;
            s_d.act_rst  = bus_wdata[7];
        end

        if (stat_wr) begin
            if (!bus_wdata[14]) s_d.uf = 1'b0;
            if (!bus_wdata[15]) s_d.re = 1'b0;
        end

        err   = refresh && s_q.run && !in_win;
        uflow = !refresh && tick && (s_q.cnt == '0);

        if (refresh) begin
            s_d.cnt = reload;
            s_d.run = 1'b1;
        end else if (tick) begin
            s_d.cnt = (s_q.cnt == '0) ? reload : s_q.cnt - 1'b1;
        end

        if (err)   s_d.re = 1'b1;
        if (uflow) s_d.uf = 1'b1;

        s_d.rst_req = (err || uflow) && s_q.act_rst;
        s_d.irq     = (err || uflow) && !s_q.act_rst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.ctrl      <= CTRL_RST;
            s_q.act_rst   <= ACT_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (bus_addr[2:1])
            2'd0:    bus_rdata = 16'h00FF;
            2'd1:    bus_rdata = s_q.ctrl;
            2'd2:    bus_rdata = {s_q.re, s_q.uf, s_q.cnt};
            default: bus_rdata = {8'h00, s_q.act_rst, 7'b0};
        endcase
    end

    assign rst_req = s_q.rst_req;
    assign irq     = s_q.irq;
    assign run_w   = s_q.run;
    assign uf_w    = s_q.uf;
    assign cnt_w   = s_q.cnt;
    assign ctrl_w  = s_q.ctrl;
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [1:0]  bus_be,
    input logic        dbg_stop,
    input logic        rst_req,
    input logic        irq,
    input logic        run_w,
    input logic        uf_w,
    input logic [13:0] cnt_w,
    input logic [15:0] ctrl_w
);
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && irq)); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |-> (cnt_w == 14'd0)); // R2

    AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        run_w |=> $stable(ctrl_w)); // R7

    AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_stop && !(bus_wr && bus_addr == 3'h0)) |=> $stable(cnt_w)); // R9

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_w && !(bus_wr && bus_addr == 3'h4 && bus_be[1])) |=> uf_w); // R6
endmodule

bind win_wdog win_wdog_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .dbg_stop (dbg_stop),
    .rst_req  (rst_req),
    .irq      (irq),
    .run_w    (run_w),
    .uf_w     (uf_w),
    .cnt_w    (cnt_w),
    .ctrl_w   (ctrl_w)
);

// File: tb/test_win_wdog.sv
module test_win_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'h0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        cnt_en = 1'b0;
    logic        dbg_stop = 1'b0;
    logic        rst_req, irq;

    always #5 clk = ~clk;

    win_wdog i_win_wdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_en(cnt_en), .dbg_stop(dbg_stop), .rst_req(rst_req), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    int m_cnt, m_pre, m_ctl;
    bit m_run, m_armed, m_ctl_used, m_act, m_act_used, m_uf, m_re, m_rst, m_irq;

    function automatic int m_reload(input int sel);
        case (sel & 3)
            0: return 1023;
            1: return 4095;
            2: return 8191;
            default: return 16383;
        endcase
    endfunction

    function automatic int m_div(input int code);
        case (code & 15)
            1: return 4;
            5: return 256;
            8: return 8192;
            default: return 1;
        endcase
    endfunction

    function automatic bit m_inwin();
        int p, r, s, e;
        p = m_reload(m_ctl) + 1;
        r = m_cnt + 1;
        case ((m_ctl >> 12) & 3)
            0: s = p / 4;
            1: s = p * 3 / 4;
            2: s = p / 2;
            default: s = p;
        endcase
        case ((m_ctl >> 8) & 3)
            0: e = p * 3 / 4;
            1: e = p / 2;
            2: e = p / 4;
            default: e = 0;
        endcase
        return (r <= s) && (r > e);
    endfunction

    function automatic int m_read(input logic [2:0] a);
        case (a[2:1])
            2'd0: return 'h00FF;
            2'd1: return m_ctl;
            2'd2: return (int'(m_re) << 15) | (int'(m_uf) << 14) | m_cnt;
            default: return int'(m_act) << 7;
        endcase
    endfunction

    always @(posedge clk) begin
        bit ev, ref_ok, hit;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_ctl = 'h33F3; m_run = 0; m_armed = 0;
            m_ctl_used = 0; m_act = 1; m_act_used = 0; m_uf = 0; m_re = 0;
            m_rst = 0; m_irq = 0;
        end else begin
            ev = 0; ref_ok = 0;
            hit = bus_wr && !bus_addr[0];
            if (hit && bus_addr == 3'h0 && bus_be[0]) begin
                ref_ok = (bus_wdata[7:0] == 8'hFF) && m_armed;
                m_armed = (bus_wdata[7:0] == 8'h00);
            end
            if (hit && bus_addr == 3'h2 && bus_be != 0 && !m_run && !m_ctl_used) begin
                m_ctl_used = 1;
                if (bus_be[0]) m_ctl = (m_ctl & 'hFF00) | bus_wdata[7:0];
                if (bus_be[1]) m_ctl = (m_ctl & 'h00FF) | (int'(bus_wdata[15:8]) << 8);
            end
            if (hit && bus_addr == 3'h6 && bus_be[0] && !m_run && !m_act_used) begin
                m_act_used = 1;
                m_act = bus_wdata[7];
            end
            if (hit && bus_addr == 3'h4 && bus_be[1]) begin
                if (!bus_wdata[14]) m_uf = 0;
                if (!bus_wdata[15]) m_re = 0;
            end
            if (ref_ok) begin
                if (m_run && !m_inwin()) begin m_re = 1; ev = 1; end
                m_cnt = m_reload(m_ctl); m_pre = 0; m_run = 1;
            end else if (m_run && cnt_en && !dbg_stop) begin
                if (m_pre == m_div(m_ctl >> 4) - 1) begin
                    m_pre = 0;
                    if (m_cnt == 0) begin m_uf = 1; ev = 1; m_cnt = m_reload(m_ctl); end
                    else m_cnt--;
                end else m_pre++;
            end
            m_rst = ev && m_act;
            m_irq = ev && !m_act;
        end
    end

    // every-cycle comparison of the action outputs (R8)
    always @(negedge clk) begin
        if (rst_n && !done)
            chk(rst_req == m_rst && irq == m_irq, "R8 action pulse",
                {rst_req, irq}, {m_rst, m_irq});
    end

    task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic kick();
        wr(3'h0, 2'b01, 16'h0000);
        wr(3'h0, 2'b01, 16'h00FF);
    endtask

    task automatic rd_model(input logic [2:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(int'(bus_rdata) == m_read(a), tag, bus_rdata, m_read(a));
    endtask

    task automatic rd_lit(input logic [2:0] a, input int exp, input int mask, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk((int'(bus_rdata) & mask) == exp, tag, int'(bus_rdata) & mask, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b0; dbg_stop = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        rd_lit(3'h4, 'h0000, 'hFFFF, "R1 status reset");
        rd_lit(3'h2, 'h33F3, 'hFFFF, "R1 control reset");
        rd_lit(3'h6, 'h0080, 'hFFFF, "R1 action reset");
        rd_lit(3'h0, 'h00FF, 'hFFFF, "R1 refresh read");
        chk(!rst_req && !irq, "R1 outputs idle", {rst_req, irq}, 0);

        // R2 malformed refresh sequences
        cnt_en = 1'b1;
        wr(3'h0, 2'b01, 16'h00FF);
        wr(3'h0, 2'b01, 16'h0000);
        wr(3'h0, 2'b01, 16'h0055);
        wr(3'h0, 2'b01, 16'h00FF);
        idle(5);
        rd_lit(3'h4, 0, 'h3FFF, "R2 counter idle before valid refresh");
        cnt_en = 1'b0;

        // R7 / R10 one-shot configuration
        wr(3'h2, 2'b11, 16'h3300);
        wr(3'h6, 2'b01, 16'h0000);
        wr(3'h2, 2'b11, 16'h0003);
        wr(3'h6, 2'b01, 16'h0080);
        rd_lit(3'h2, 'h3300, 'hFFFF, "R7 second control write ignored");
        rd_lit(3'h6, 'h0000, 'hFFFF, "R7 second action write ignored");

        // R3 reload 03FFh
        kick();
        rd_lit(3'h4, 'h03FF, 'h3FFF, "R3 reload 1024");
        wr(3'h2, 2'b11, 16'h3301);
        rd_lit(3'h2, 'h3300, 'hFFFF, "R7 control locked after refresh");

        // R6 / R8 underflow to interrupt
        cnt_en = 1'b1;
        idle(1100);
        cnt_en = 1'b0;
        rd_lit(3'h4, 'h4000, 'h4000, "R6 underflow flag set");
        rd_model(3'h4, "R6 status vs model");
        wr(3'h4, 2'b11, 16'hFFFF);
        rd_lit(3'h4, 'h4000, 'hC000, "R6 writing ones keeps flag");
        wr(3'h4, 2'b10, 16'h0000);
        rd_lit(3'h4, 'h0000, 'hC000, "R6 writing zero clears flags");

        // R4 / R9 prescaler /4 and debug stop
        do_reset();
        wr(3'h2, 2'b11, 16'h3311);
        kick();
        rd_lit(3'h4, 'h0FFF, 'h3FFF, "R3 reload 4096");
        cnt_en = 1'b1;
        idle(8);
        cnt_en = 1'b0;
        rd_lit(3'h4, 'h0FFD, 'h3FFF, "R4 divide by 4");
        dbg_stop = 1'b1; cnt_en = 1'b1;
        idle(40);
        dbg_stop = 1'b0; cnt_en = 1'b0;
        rd_lit(3'h4, 'h0FFD, 'h3FFF, "R9 debug stop holds count");
        idle(20);
        rd_lit(3'h4, 'h0FFD, 'h3FFF, "R4 cnt_en low holds count");

        // R5 early refresh, start window 25%, reset mode
        do_reset();
        wr(3'h2, 2'b11, 16'h0300);
        kick();
        kick();
        rd_lit(3'h4, 'h8000, 'h8000, "R5 early refresh flagged");
        wr(3'h4, 2'b10, 16'h0000);
        cnt_en = 1'b1;
        idle(900);
        cnt_en = 1'b0;
        kick();
        rd_lit(3'h4, 'h03FF, 'hBFFF, "R5 in-window refresh clean");

        // R5 late refresh, end window 75%, interrupt mode
        do_reset();
        wr(3'h2, 2'b11, 16'h3000);
        wr(3'h6, 2'b01, 16'h0000);
        kick();
        kick();
        rd_lit(3'h4, 'h0000, 'h8000, "R5 refresh inside upper window");
        cnt_en = 1'b1;
        idle(400);
        cnt_en = 1'b0;
        kick();
        rd_lit(3'h4, 'h8000, 'h8000, "R5 late refresh flagged");

        // R3 other reloads, R4 larger dividers, R10 byte lanes
        do_reset();
        kick();
        rd_lit(3'h4, 'h3FFF, 'h3FFF, "R3 reload 16384");
        do_reset();
        wr(3'h2, 2'b11, 16'h3302);
        kick();
        rd_lit(3'h4, 'h1FFF, 'h3FFF, "R3 reload 8192");
        do_reset();
        wr(3'h2, 2'b11, 16'h3350);
        kick();
        cnt_en = 1'b1;
        idle(512);
        cnt_en = 1'b0;
        rd_lit(3'h4, 'h03FD, 'h3FFF, "R4 divide by 256");
        do_reset();
        wr(3'h2, 2'b11, 16'h3380);
        kick();
        cnt_en = 1'b1;
        idle(8192);
        cnt_en = 1'b0;
        rd_lit(3'h4, 'h03FE, 'h3FFF, "R4 divide by 8192");
        do_reset();
        wr(3'h3, 2'b11, 16'h0000);
        rd_lit(3'h2, 'h33F3, 'hFFFF, "R10 misaligned write ignored");
        wr(3'h2, 2'b01, 16'hAA01);
        rd_lit(3'h2, 'h3301, 'hFFFF, "R10 low lane only");
        rd_model(3'h2, "R10 control vs model");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule